// File: doc/BRIEF.md
# Capture-Transform-Drain Sequencer

This block is the top-level control engine of a small spectrum pipeline. It fills a 32-slot transform memory from an ADC front end one sample at a time. It then starts the FFT engine and waits for it to finish. After that it hands the 32 result words to an external host, one word per handshake. The ADC interface, the FFT datapath and the memory sit outside the block. The sequencer drives their strobes and a shared slot address, and it watches their done pulses.

The host paces the readout with two wires. The block raises a word-available line while the host holds its ready line high. When the host drops ready, the block moves to the next slot and waits for ready to return. If the host is not ready at the moment the transform completes, the block discards that readout and starts a fresh capture. A separate serializer, clocked by the host's own clock, shifts the presented result word out least significant bit first.

Top module: `xform_sequencer`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the block enters the capture-start phase: `smp_req`=1, `mem_load`=`fft_go`=`mem_drain`=`word_avail`=0, `slot_addr`=0. A rising `host_clk` edge with `rst` high clears the bit index and drives `host_sdo` to 0.
- R2: In capture, `smp_req` stays high until `smp_done` is sampled high. The next cycle carries a single-cycle `mem_load` at the current `slot_addr`, and the address then advances by one. One pass loads slots 0 through 31 in ascending order.
- R3: After the load of slot 31, `fft_go` is high for exactly two consecutive cycles. The block then waits, with no strobe active, until `fft_fin` is sampled high.
- R4: In the cycle after `fft_fin` is sampled, `mem_drain` is high and `slot_addr` is 0.
- R5: If `host_rdy` is low in that first readout cycle, the next cycle returns to capture start (`smp_req`=1, `mem_drain`=0, `slot_addr`=0) and no word is offered.
- R6: During readout, `word_avail` rises the cycle after `host_rdy` is sampled high and stays high while `host_rdy` stays high. It falls the cycle after `host_rdy` is sampled low. `slot_addr` then advances by one, and the block waits with `word_avail` low until `host_rdy` rises again.
- R7: After the host releases the word at slot 31, the block returns to capture start with `slot_addr`=0.
- R8: `host_sdo` takes bit k of `result_word` on the k-th rising `host_clk` edge after reset (k from 0). The index wraps from 31 back to 0.
- R9: At most one of `smp_req`, `mem_load`, `fft_go` and `mem_drain` is high in any cycle, and `word_avail` is high only together with `mem_drain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_req | output | 1 | ADC conversion enable |
| smp_done | input | 1 | ADC sample ready pulse |
| mem_load | output | 1 | Write the captured sample into slot `slot_addr` |
| fft_go | output | 1 | FFT start, two cycles wide |
| fft_fin | input | 1 | FFT finished pulse |
| mem_drain | output | 1 | Memory in readout mode |
| slot_addr | output | 5 | Shared memory slot address |
| host_rdy | input | 1 | Host ready line |
| word_avail | output | 1 | Word at `slot_addr` is available to the host |
| host_clk | input | 1 | Host serial clock |
| result_word | input | 32 | Result word read from memory |
| host_sdo | output | 1 | Serial data to the host |

## Verification
A corrupted phase shows up within one cycle as a wrong strobe set on the ports. An example is `smp_req` and `mem_drain` high together, or `fft_go` lasting one or three cycles. A slip in the slot counter is not visible at once. It appears on the next `mem_load` or `word_avail` rise as an address that breaks the ascending 0–31 order, and at the latest at the end of the pass, when the transform starts early or late. A serializer index error appears on the very next `host_clk` edge as a wrong bit against the word presented.

// File: rtl/xform_seq_pkg.sv
package xform_seq_pkg;

    typedef enum logic [3:0] {
        PH_CAP_REQ,
        PH_CAP_WAIT,
        PH_CAP_STORE,
        PH_FFT_GO_A,
        PH_FFT_GO_B,
        PH_FFT_WAIT,
        PH_DRN_CHECK,
        PH_DRN_SEND,
        PH_DRN_STEP,
        PH_DRN_IDLE
    } phase_e;

    typedef struct packed {
        logic smp_req;
        logic mem_load;
        logic fft_go;
        logic mem_drain;
        logic word_avail;
    } strobe_t;

    function automatic strobe_t phase_strobes(phase_e ph);
        strobe_t s;
        s = '0;
        case (ph)
            PH_CAP_REQ, PH_CAP_WAIT:   s.smp_req  = 1'b1;
            PH_CAP_STORE:              s.mem_load = 1'b1;
            PH_FFT_GO_A, PH_FFT_GO_B:  s.fft_go   = 1'b1;
            PH_DRN_CHECK, PH_DRN_STEP,
            PH_DRN_IDLE:               s.mem_drain = 1'b1;
            PH_DRN_SEND: begin
                s.mem_drain  = 1'b1;
                s.word_avail = 1'b1;
            end
            default:                   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xform_seq_fsm.sv
module xform_seq_fsm
    import xform_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    smp_done,
    input  logic    fft_fin,
    input  logic    host_rdy,
    input  logic    addr_last,
    output logic    addr_clr,
    output logic    addr_inc,
    output strobe_t strb_q
);

    phase_e cur, nxt;

    always_comb begin
        nxt      = cur;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        case (cur)
            PH_CAP_REQ:  nxt = PH_CAP_WAIT;
            PH_CAP_WAIT: if (smp_done) nxt = PH_CAP_STORE;
            PH_CAP_STORE: begin
                if (addr_last) begin
                    nxt      = PH_FFT_GO_A;
                    addr_clr = 1'b1;
                end else begin
                    nxt      = PH_CAP_REQ;
                    addr_inc = 1'b1;
                end
            end
            PH_FFT_GO_A: nxt = PH_FFT_GO_B;
            PH_FFT_GO_B: nxt = PH_FFT_WAIT;
            PH_FFT_WAIT: begin
                if (fft_fin) begin
                    nxt      = PH_DRN_CHECK;
                    addr_clr = 1'b1;
                end
            end
            PH_DRN_CHECK: begin
                if (host_rdy) begin
                    nxt = PH_DRN_SEND;
                end else begin
                    nxt      = PH_CAP_REQ;
                    addr_clr = 1'b1;
                end
            end
            PH_DRN_SEND: if (!host_rdy) nxt = PH_DRN_STEP;
            PH_DRN_STEP: begin
                if (addr_last) begin
                    nxt      = PH_CAP_REQ;
                    addr_clr = 1'b1;
                end else begin
                    nxt      = PH_DRN_IDLE;
                    addr_inc = 1'b1;
                end
            end
            PH_DRN_IDLE: if (host_rdy) nxt = PH_DRN_SEND;
            default: begin
                nxt      = PH_CAP_REQ;
                addr_clr = 1'b1;
            end
        endcase
    end

    // Strobes are registered from the next phase so they line up with cur.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= PH_CAP_REQ;
            strb_q <= phase_strobes(PH_CAP_REQ);
        end else begin
            cur    <= nxt;
            strb_q <= phase_strobes(nxt);
        end
    end

endmodule

// File: rtl/xform_seq_slot_ctr.sv
module xform_seq_slot_ctr #(
    parameter int SLOTS = 32,
    localparam int AW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] cnt,
    output logic          at_last
);

    localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (inc)         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign at_last = (cnt == LAST);

endmodule

// File: rtl/xform_seq_serializer.sv
module xform_seq_serializer #(
    parameter int WORD_W = 32,
    localparam int IW    = $clog2(WORD_W)
) (
    input  logic              host_clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    output logic              sdo
);

    localparam logic [IW-1:0] TOP_IDX = IW'(WORD_W - 1);

    logic [IW-1:0] idx;

    always_ff @(posedge host_clk) begin
        if (rst) begin
            idx <= '0;
            sdo <= 1'b0;
        end else begin
            sdo <= word[idx];
            idx <= (idx == TOP_IDX) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/xform_sequencer.sv
module xform_sequencer
    import xform_seq_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic                     smp_req,
    input  logic                     smp_done,
    output logic                     mem_load,
    output logic                     fft_go,
    input  logic                     fft_fin,
    output logic                     mem_drain,
    output logic [$clog2(SLOTS)-1:0] slot_addr,
    input  logic                     host_rdy,
    output logic                     word_avail,
    input  logic                     host_clk,
    input  logic [WORD_W-1:0]        result_word,
    output logic                     host_sdo
);

    localparam int ADDR_W = $clog2(SLOTS);

    strobe_t strb;
    logic    addr_clr, addr_inc, addr_last;

    xform_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .smp_done  (smp_done),
        .fft_fin   (fft_fin),
        .host_rdy  (host_rdy),
        .addr_last (addr_last),
        .addr_clr  (addr_clr),
        .addr_inc  (addr_inc),
        .strb_q    (strb)
    );

    xform_seq_slot_ctr #(.SLOTS(SLOTS)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .clr     (addr_clr),
        .inc     (addr_inc),
        .cnt     (slot_addr),
        .at_last (addr_last)
    );

    xform_seq_serializer #(.WORD_W(WORD_W)) u_ser (
        .host_clk (host_clk),
        .rst      (rst),
        .word     (result_word),
        .sdo      (host_sdo)
    );

    assign smp_req    = strb.smp_req;
    assign mem_load   = strb.mem_load;
    assign fft_go     = strb.fft_go;
    assign mem_drain  = strb.mem_drain;
    assign word_avail = strb.word_avail;

    initial begin
        if (ADDR_W < 1) $error("SLOTS must be at least 2");
    end

endmodule

// File: rtl/xform_sequencer_chk.sv
module xform_sequencer_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_req,
    input logic          smp_done,
    input logic          mem_load,
    input logic          fft_go,
    input logic          fft_fin,
    input logic          mem_drain,
    input logic [AW-1:0] slot_addr,
    input logic          host_rdy,
    input logic          word_avail
);

    localparam logic [AW-1:0] LAST = '1;

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smp_req, mem_load, fft_go, mem_drain})); // R9

    AST_AVAIL_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
        word_avail |-> mem_drain); // R9

    AST_LOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_load |-> $past(smp_done)); // R2

    AST_GO_SECOND_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $rose(fft_go) |=> fft_go); // R3

    AST_GO_ENDS: assert property (@(posedge clk) disable iff (rst)
        (fft_go && $past(fft_go)) |=> !fft_go); // R3

    AST_LAST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        (mem_load && slot_addr == LAST) |=> fft_go); // R3

    AST_DRAIN_AFTER_FIN: assert property (@(posedge clk) disable iff (rst)
        (fft_fin && !smp_req && !mem_load && !fft_go && !mem_drain)
            |=> (mem_drain && slot_addr == '0)); // R4

    AST_AVAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (word_avail && host_rdy) |=> word_avail); // R6

endmodule

bind xform_sequencer xform_sequencer_chk #(.AW(ADDR_W)) u_chk (.*);

// File: tb/xform_sequencer_tb.sv
module xform_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 20000;
    localparam int NSLOT      = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_done = 1'b0;
    logic        fft_fin = 1'b0;
    logic        host_rdy = 1'b0;
    logic        host_clk = 1'b0;
    logic [31:0] result_word = '0;
    logic        smp_req, mem_load, fft_go, mem_drain, word_avail, host_sdo;
    logic [4:0]  slot_addr;

    xform_sequencer u_dut (
        .clk         (clk),
        .rst         (rst),
        .smp_req     (smp_req),
        .smp_done    (smp_done),
        .mem_load    (mem_load),
        .fft_go      (fft_go),
        .fft_fin     (fft_fin),
        .mem_drain   (mem_drain),
        .slot_addr   (slot_addr),
        .host_rdy    (host_rdy),
        .word_avail  (word_avail),
        .host_clk    (host_clk),
        .result_word (result_word),
        .host_sdo    (host_sdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int kind; int addr; } ev_t;  // kind 0 load, 1 go, 2 avail
    ev_t exp_q[$];

    int  n_cmp = 0, n_bad = 0, fin_count = 0;
    bit  mon_on = 1'b0, finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver side of the scoreboard
    task automatic push_capture();
        for (int a = 0; a < NSLOT; a++) exp_q.push_back('{0, a});  // R2
        exp_q.push_back('{1, 0});                                   // R3
    endtask

    task automatic push_drain();
        for (int a = 0; a < NSLOT; a++) exp_q.push_back('{2, a});  // R6
    endtask

    task automatic take_ev(input int kind, input int addr, input string req);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, req, "unexpected event kind*100+addr", kind*100+addr, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind && e.addr == addr, req, "event kind*100+addr",
                  kind*100+addr, e.kind*100+e.addr);
        end
    endtask

    // Monitor side
    initial begin
        logic prev_go, prev_av;
        prev_go = 1'b0;
        prev_av = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                check($countones({smp_req, mem_load, fft_go, mem_drain}) <= 1
                      && (!word_avail || mem_drain), "R9", "strobe set",
                      int'({smp_req, mem_load, fft_go, mem_drain, word_avail}), 0);
                if (mem_load)               take_ev(0, int'(slot_addr), "R2");
                if (fft_go && !prev_go)     take_ev(1, 0, "R3");
                if (word_avail && !prev_av) take_ev(2, int'(slot_addr), "R6");
            end
            prev_go = fft_go;
            prev_av = word_avail;
        end
    end

    // ADC model
    task automatic adc_model();
        forever begin
            do @(negedge clk); while (!smp_req);
            repeat (2) @(negedge clk);
            smp_done = 1'b1;
            @(negedge clk);
            smp_done = 1'b0;
        end
    endtask

    // FFT model
    task automatic fft_model();
        int width;
        forever begin
            do @(negedge clk); while (!fft_go);
            width = 0;
            while (fft_go) begin
                width++;
                @(negedge clk);
            end
            check(width == 2, "R3", "fft_go width", width, 2);
            repeat (3) @(negedge clk);
            check(!smp_req && !mem_drain && !mem_load && !fft_go, "R3",
                  "idle while waiting", int'({smp_req, mem_drain}), 0);
            fft_fin = 1'b1;
            @(negedge clk);
            fft_fin = 1'b0;
            fin_count++;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        #1 host_clk = 1'b1;
        #1 host_clk = 1'b0;
        // R1 reset state
        check(smp_req == 1'b1, "R1", "smp_req", int'(smp_req), 1);
        check({mem_load, fft_go, mem_drain, word_avail} == 4'b0, "R1",
              "other strobes", int'({mem_load, fft_go, mem_drain, word_avail}), 0);
        check(slot_addr == 5'd0, "R1", "slot_addr", int'(slot_addr), 0);
        check(host_sdo == 1'b0, "R1", "host_sdo", int'(host_sdo), 0);
        @(negedge clk);
        rst = 1'b0;
        push_capture();
        mon_on = 1'b1;
        fork
            adc_model();
            fft_model();
        join_none

        // R8 serializer, including wrap after bit 31
        w = 32'hA5C3_0F96;
        result_word = w;
        for (int k = 0; k < 40; k++) begin
            if (k == 32) begin
                w = 32'h3C96_E71B;
                result_word = w;
            end
            #1 host_clk = 1'b1;
            #1 host_clk = 1'b0;
            check(host_sdo == w[k % 32], "R8", "serial bit", int'(host_sdo), int'(w[k % 32]));
        end

        // First transform with host not ready
        wait (fin_count == 1);
        check(mem_drain == 1'b1 && slot_addr == 5'd0, "R4", "drain entry",
              int'({mem_drain, slot_addr}), 32);
        check(word_avail == 1'b0, "R5", "no word offered", int'(word_avail), 0);
        @(negedge clk);
        check(smp_req == 1'b1 && mem_drain == 1'b0 && slot_addr == 5'd0, "R5",
              "fallback to capture", int'({smp_req, mem_drain, slot_addr}), 64);
        push_capture();
        push_drain();
        host_rdy = 1'b1;

        // Readout of 32 words
        for (int i = 0; i < NSLOT; i++) begin
            do @(negedge clk); while (!word_avail);
            check(slot_addr == 5'(i), "R6", "offered slot", int'(slot_addr), i);
            repeat (3) @(negedge clk);
            check(word_avail == 1'b1, "R6", "held while ready", int'(word_avail), 1);
            host_rdy = 1'b0;
            @(negedge clk);
            check(word_avail == 1'b0, "R6", "drops after release", int'(word_avail), 0);
            repeat (2) @(negedge clk);
            if (i == NSLOT - 1) begin
                check(smp_req == 1'b1 && mem_drain == 1'b0 && slot_addr == 5'd0, "R7",
                      "capture after last word", int'({smp_req, mem_drain, slot_addr}), 64);
                push_capture();
            end else begin
                check(word_avail == 1'b0 && mem_drain == 1'b1, "R6", "waits for ready",
                      int'({word_avail, mem_drain}), 1);
                check(slot_addr == 5'(i + 1), "R6", "next slot", int'(slot_addr), i + 1);
                host_rdy = 1'b1;
            end
        end

        wait (fin_count == 3);
        mon_on = 1'b0;
        check(exp_q.size() == 0, "R7", "events left in queue", exp_q.size(), 0);
        summary();
    end

endmodule